// File: doc/BRIEF.md
# Flash Bank Query and Identifier Read Responder

This block forms the read data returned by a parallel flash bank while the bank is in query mode or identifier mode. The bank is built from one or more identical flash devices placed side by side on the bus. Each device may be wired narrower than its widest supported width. A bus read presents a byte address and an access size. The block turns the address into a device-relative table index, fetches either a byte of the built-in parameter table or one of two identifier codes, and spreads the per-device answer across every device lane of the bank.

Three width settings are given as base-2 logarithms: the bank width, the width at which each device is used, and the device's widest supported width. All of them are 1, 2 or 4 bytes. When a read is wider than the bank, the block runs several lookups at successive bank-sized address steps and packs their results side by side. The answer is registered, so data is valid one clock after the read strobe. Command decoding belongs to the surrounding controller.

Top module: `flash_query_unit`

## Requirements
- R1: After reset `rd_valid` and `rd_data` are zero. Each cycle `rd_valid` equals `rd_en` of the previous cycle. `rd_data` takes the new response one clock after a strobe and keeps its value while `rd_en` is low.
- R2: The index of a lookup is its byte address shifted right by `cfg_bank_lg + cfg_max_lg - cfg_dev_lg`.
- R3: In query mode (`rd_ident` = 0), an index of 82 (0x52) or more gives zero in every byte of the lookup.
- R4: The query table holds 0x51, 0x52 and 0x59 at indices 0x10, 0x11 and 0x12, and 0x01 at index 0x2C. Indices 0x00 to 0x0F hold zero.
- R5: In query mode with `cfg_dev_lg == cfg_max_lg`, each device lane holds the table byte in its lowest byte and zero in its upper bytes.
- R6: In query mode with `cfg_dev_lg < cfg_max_lg`, a device used at 1 byte returns the table byte in every byte. Any wider device used below its maximum returns zero.
- R7: The per-device value fills each device-width lane of the bank, from byte 0 up to the bank width.
- R8: In identifier mode (`rd_ident` = 1), only bits 7:0 of the index are decoded. 0 selects `mfr_code`, 1 selects `dev_code`, and any other value gives zero. The code is cut to the device width, or zero-extended when the device is 4 bytes wide.
- R9: When the access size exceeds the bank width, lookup k uses address `rd_addr + k*bank_width`. Its bank-wide result lands at byte offset `k*bank_width` of `rd_data`, with lookup 0 in the lowest bytes.
- R10: Bytes of `rd_data` at or above the access size (1 << `rd_size` bytes) read zero. An access narrower than the bank returns the low bytes of a single lookup.
- R11: A read is legal only when every width code is 0 to 2, `cfg_dev_lg <= cfg_bank_lg` and `cfg_dev_lg <= cfg_max_lg`. A strobe with any other setting breaks a design assertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_ident | input | 1 | 0 = query table, 1 = identifier codes |
| rd_addr | input | ADDR_W | Bus byte address |
| rd_size | input | 2 | log2 of access size in bytes |
| cfg_bank_lg | input | 2 | log2 of bank width in bytes |
| cfg_dev_lg | input | 2 | log2 of device width in use |
| cfg_max_lg | input | 2 | log2 of widest device width |
| mfr_code | input | ID_W | Manufacturer code |
| dev_code | input | ID_W | Device code |
| rd_data | output | 8*BUS_BYTES | Registered response |
| rd_valid | output | 1 | Response valid, one cycle after `rd_en` |

## Verification
A wrong shift amount moves the looked-up index. It shows on the very next valid response as a table byte from the wrong position, for example a zero where 0x51 is expected or an identifier code at the wrong address. A lane-packing or replication fault shows in that same response as a byte in the wrong position or a missing copy. A stale output register shows as data that changes on a cycle with no strobe. Sweeping every legal width setting, size and mode over a range of addresses exposes each of these within one read.

// File: rtl/fq_pkg.sv
package fq_pkg;

    localparam int LG_W = 2;

    typedef logic [LG_W-1:0] lg_t;

    typedef struct packed {
        lg_t bank_lg;
        lg_t dev_lg;
        lg_t max_lg;
    } fq_cfg_t;

    typedef enum logic {
        FQ_QUERY = 1'b0,
        FQ_IDENT = 1'b1
    } fq_mode_e;

    // Parameter table contents, computed from the array geometry.
    function automatic logic [7:0] fq_table_byte(
        input logic [7:0]  idx,
        input int unsigned size_lg,
        input int unsigned blocks,
        input int unsigned sector_bytes,
        input int unsigned wbuf_lg
    );
        logic [7:0] v;
        v = 8'h00;
        case (idx)
            8'h2C: v = 8'h01;                       // one uniform erase region
            8'h10: v = 8'h51;                       // "Q"
            8'h12: v = 8'h59;                       // "Y"
            8'h11: v = 8'h52;                       // "R"
            8'h27: v = 8'(size_lg);
            8'h2A: v = 8'(wbuf_lg);
            8'h2D: v = 8'((blocks - 1) & 32'hFF);
            8'h2E: v = 8'(((blocks - 1) >> 8) & 32'hFF);
            8'h2F: v = 8'((sector_bytes >> 8) & 32'hFF);
            8'h30: v = 8'((sector_bytes >> 16) & 32'hFF);
            8'h13: v = 8'h01;                       // command set code
            8'h15: v = 8'h31;                       // extended table pointer
            8'h28: v = 8'h02;                       // interface code
            8'h31: v = 8'h50;
            8'h32: v = 8'h52;
            8'h33: v = 8'h49;
            8'h34: v = 8'h31;
            8'h35: v = 8'h30;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fq_index.sv
module fq_index
    import fq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  fq_cfg_t           cfg,
    output logic [ADDR_W-1:0] idx
);
    logic [LG_W:0] shamt;

    // Bank lanes and the unused upper device address bits are dropped.
    assign shamt = {1'b0, cfg.bank_lg} + {1'b0, cfg.max_lg} - {1'b0, cfg.dev_lg};
    assign idx   = addr >> shamt;

endmodule

// File: rtl/fq_lookup.sv
module fq_lookup
    import fq_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int BUS_BYTES    = 4,
    parameter int ID_W         = 16,
    parameter int TBL_LEN      = 82,
    parameter int SIZE_LG      = 22,
    parameter int NUM_BLOCKS   = 64,
    parameter int SECTOR_BYTES = 65536,
    parameter int WBUF_LG      = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  fq_mode_e               mode,
    input  logic [ADDR_W-1:0]      idx,
    input  fq_cfg_t                cfg,
    input  logic [ID_W-1:0]        mfr,
    input  logic [ID_W-1:0]        devc,
    output logic [8*BUS_BYTES-1:0] bank_word
);
    localparam int DATA_W = 8 * BUS_BYTES;

    logic             in_rng;
    logic [7:0]       tbyte;
    logic [DATA_W-1:0] dev_word;

    assign in_rng = idx < ADDR_W'(TBL_LEN);
    assign tbyte  = in_rng ? fq_table_byte(idx[7:0], SIZE_LG, NUM_BLOCKS,
                                           SECTOR_BYTES, WBUF_LG) : 8'h00;

    // Value produced by one device.
    always_comb begin
        dev_word = '0;
        if (mode == FQ_IDENT) begin
            case (idx[7:0])
                8'd0:    dev_word = DATA_W'(mfr);
                8'd1:    dev_word = DATA_W'(devc);
                default: dev_word = '0;
            endcase
        end else if (cfg.dev_lg == cfg.max_lg) begin
            dev_word = DATA_W'(tbyte);
        end else if (cfg.dev_lg == '0) begin
            dev_word = {BUS_BYTES{tbyte}};
        end
    end

    // Copy the device value into every device lane of the bank.
    always_comb begin
        bank_word = '0;
        for (int b = 0; b < BUS_BYTES; b++) begin
            if (b < (1 << cfg.bank_lg))
                bank_word[8*b +: 8] = dev_word[8*(b & ((1 << cfg.dev_lg) - 1)) +: 8];
        end
    end

    a_r3_beyond_table: assert property (@(posedge clk) disable iff (rst)
        (mode == FQ_QUERY && idx >= ADDR_W'(TBL_LEN)) |-> bank_word == '0);

    a_r8_ident_other_zero: assert property (@(posedge clk) disable iff (rst)
        (mode == FQ_IDENT && idx[7:0] > 8'd1) |-> bank_word == '0);

    a_r7_byte_lane_copy: assert property (@(posedge clk) disable iff (rst)
        (cfg.dev_lg == '0 && cfg.bank_lg != '0) |-> bank_word[15:8] == bank_word[7:0]);

endmodule

// File: rtl/flash_query_unit.sv
module flash_query_unit
    import fq_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int BUS_BYTES    = 4,
    parameter int ID_W         = 16,
    parameter int TBL_LEN      = 82,
    parameter int NUM_BLOCKS   = 64,
    parameter int SECTOR_BYTES = 65536,
    parameter int WBUF_LG      = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_en,
    input  logic                   rd_ident,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [1:0]             rd_size,
    input  logic [1:0]             cfg_bank_lg,
    input  logic [1:0]             cfg_dev_lg,
    input  logic [1:0]             cfg_max_lg,
    input  logic [ID_W-1:0]        mfr_code,
    input  logic [ID_W-1:0]        dev_code,
    output logic [8*BUS_BYTES-1:0] rd_data,
    output logic                   rd_valid
);
    localparam int DATA_W  = 8 * BUS_BYTES;
    localparam int LG_MAX  = $clog2(BUS_BYTES);
    localparam int SIZE_LG = $clog2(NUM_BLOCKS * SECTOR_BYTES);

    fq_cfg_t  cfg;
    fq_mode_e mode;

    assign cfg  = '{bank_lg: cfg_bank_lg, dev_lg: cfg_dev_lg, max_lg: cfg_max_lg};
    assign mode = rd_ident ? FQ_IDENT : FQ_QUERY;

    logic [BUS_BYTES-1:0][DATA_W-1:0] lane_word;

    // One lookup per possible bank step inside the widest access.
    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_step
        logic [ADDR_W-1:0] step_addr;
        logic [ADDR_W-1:0] step_idx;

        assign step_addr = rd_addr + ADDR_W'(k << cfg_bank_lg);

        fq_index #(.ADDR_W(ADDR_W)) u_index (
            .addr (step_addr),
            .cfg  (cfg),
            .idx  (step_idx)
        );

        fq_lookup #(
            .ADDR_W       (ADDR_W),
            .BUS_BYTES    (BUS_BYTES),
            .ID_W         (ID_W),
            .TBL_LEN      (TBL_LEN),
            .SIZE_LG      (SIZE_LG),
            .NUM_BLOCKS   (NUM_BLOCKS),
            .SECTOR_BYTES (SECTOR_BYTES),
            .WBUF_LG      (WBUF_LG)
        ) u_lookup (
            .clk       (clk),
            .rst       (rst),
            .mode      (mode),
            .idx       (step_idx),
            .cfg       (cfg),
            .mfr       (mfr_code),
            .devc      (dev_code),
            .bank_word (lane_word[k])
        );
    end

    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] packed_word;

    always_comb begin
        size_mask = '0;
        for (int b = 0; b < BUS_BYTES; b++) begin
            if (b < (1 << rd_size))
                size_mask[8*b +: 8] = 8'hFF;
        end
    end

    always_comb begin
        packed_word = '0;
        for (int k = 0; k < BUS_BYTES; k++) begin
            if ((k << cfg_bank_lg) < (1 << rd_size))
                packed_word = packed_word | (lane_word[k] << (8 * (k << cfg_bank_lg)));
        end
        packed_word = packed_word & size_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= packed_word;
        end
    end

    a_r1_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && $stable(rd_data)));

    a_r10_single_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_size == 2'd0) |=> rd_data[DATA_W-1:8] == '0);

    a_r11_legal_widths: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (int'(cfg_bank_lg) <= LG_MAX && int'(cfg_max_lg) <= LG_MAX &&
                   int'(rd_size) <= LG_MAX && cfg_dev_lg <= cfg_bank_lg &&
                   cfg_dev_lg <= cfg_max_lg));

endmodule

// File: tb/flash_query_unit_test.sv
`timescale 1ns/1ps
module flash_query_unit_test;

    localparam int ADDR_W = 12;
    localparam logic [15:0] MFR = 16'hC3B2;
    localparam logic [15:0] DEV = 16'h7E41;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        rd_ident = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [1:0]  rd_size = 2'd0;
    logic [1:0]  cfg_bank_lg = 2'd0;
    logic [1:0]  cfg_dev_lg = 2'd0;
    logic [1:0]  cfg_max_lg = 2'd0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flash_query_unit uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_ident(rd_ident),
        .rd_addr(rd_addr), .rd_size(rd_size), .cfg_bank_lg(cfg_bank_lg),
        .cfg_dev_lg(cfg_dev_lg), .cfg_max_lg(cfg_max_lg),
        .mfr_code(MFR), .dev_code(DEV), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic set_cfg(input int bl, input int dl, input int ml);
        cfg_bank_lg = 2'(bl);
        cfg_dev_lg  = 2'(dl);
        cfg_max_lg  = 2'(ml);
    endtask

    // One strobe; sampled at the falling edge after the capturing rising edge.
    task automatic do_read(input bit id, input int a, input int sz, output logic [31:0] d);
        @(negedge clk);
        rd_ident = id;
        rd_addr  = ADDR_W'(a);
        rd_size  = 2'(sz);
        rd_en    = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R1 valid", {31'd0, rd_valid}, 32'd1);
        d = rd_data;
    endtask

    function automatic int tab_byte(input int ix, output bit known);
        known = 1;
        if (ix >= 82) return 0;
        if (ix < 16) return 0;
        if (ix == 16) return 8'h51;
        if (ix == 17) return 8'h52;
        if (ix == 18) return 8'h59;
        if (ix == 44) return 8'h01;
        known = 0;
        return 0;
    endfunction

    // Byte-level expectation built from the requirements.
    function automatic logic [31:0] model(input bit id, input int a, input int bl,
                                          input int dl, input int ml, input int sz,
                                          output bit known);
        int bw, dw, mw, sw, steps;
        logic [31:0] res;
        bw = 1 << bl; dw = 1 << dl; mw = 1 << ml; sw = 1 << sz;
        steps = (sw > bw) ? sw / bw : 1;
        res = 0;
        known = 1;
        for (int k = 0; k < steps; k++) begin
            int ix;
            ix = (a + k * bw) / (1 << (bl + ml - dl));
            for (int j = 0; j < bw; j++) begin
                int pos, bv, dj;
                bit kn;
                pos = k * bw + j;
                dj = j % dw;
                bv = 0;
                if (pos < sw) begin
                    if (id) begin
                        int code;
                        code = (ix % 256 == 0) ? int'(MFR) : (ix % 256 == 1) ? int'(DEV) : 0;
                        bv = (dj < 2) ? ((code / (1 << (8 * dj))) % 256) : 0;
                    end else begin
                        int tb;
                        tb = tab_byte(ix, kn);
                        if (!kn) known = 0;
                        if (dw == mw) bv = (dj == 0) ? tb : 0;
                        else if (dw == 1) bv = tb;
                        else bv = 0;
                    end
                    res[8*pos +: 8] = 8'(bv);
                end
            end
        end
        return res;
    endfunction

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp;
        bit kn;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", {31'd0, rd_valid}, 32'd0);
        check("R1 reset data", rd_data, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R4: table contents, single-byte bank
        set_cfg(0, 0, 0);
        do_read(0, 16'h10, 0, d); check("R4 Q", d, 32'h51);
        do_read(0, 16'h11, 0, d); check("R4 R", d, 32'h52);
        do_read(0, 16'h12, 0, d); check("R4 Y", d, 32'h59);
        do_read(0, 16'h2C, 0, d); check("R4 region count", d, 32'h01);
        do_read(0, 16'h05, 0, d); check("R4 low zero", d, 32'h0);
        // R3: out of table
        do_read(0, 16'h52, 0, d); check("R3 first past end", d, 32'h0);
        do_read(0, 16'hFF, 0, d); check("R3 far past end", d, 32'h0);
        // R9: query lookups packed lowest first
        do_read(0, 16'h0F, 2, d); check("R9 query pack", d, 32'h59525100);
        // R8: only index bits 7:0 decoded
        do_read(1, 16'h100, 0, d); check("R8 index wrap", d, 32'hB2);

        // R2 + R6: shift 4, 1-byte use of a 4-byte device
        set_cfg(2, 0, 2);
        do_read(0, 16'h100, 2, d); check("R2 shift four", d, 32'h51515151);
        check("R6 x8 repeat", d, 32'h51515151);
        // R1: idle cycle holds data and drops valid
        @(negedge clk);
        check("R1 idle valid", {31'd0, rd_valid}, 32'd0);
        check("R1 idle hold", rd_data, 32'h51515151);

        // R5: matched 2-byte devices, zero upper byte
        set_cfg(2, 1, 1);
        do_read(0, 16'h44, 2, d); check("R5 zero extend", d, 32'h00520052);
        // R6: wider device below its maximum gives zero
        set_cfg(2, 1, 2);
        do_read(0, 16'h80, 2, d); check("R6 unsupported", d, 32'h0);
        // R7: byte devices across a 4-byte bank
        set_cfg(2, 0, 0);
        do_read(0, 16'h48, 2, d); check("R7 replicate", d, 32'h59595959);

        // R8: identifier codes
        set_cfg(1, 1, 1);
        do_read(1, 0, 1, d); check("R8 manufacturer", d, 32'hC3B2);
        do_read(1, 2, 1, d); check("R8 device", d, 32'h7E41);
        do_read(1, 4, 1, d); check("R8 other zero", d, 32'h0);
        // R9: two identifier lookups in one wide access
        do_read(1, 0, 2, d); check("R9 ident pack", d, 32'h7E41C3B2);
        set_cfg(1, 0, 0);
        do_read(1, 0, 1, d); check("R8 truncate and R7 copy", d, 32'hB2B2);
        // R11: widest legal setting
        set_cfg(2, 2, 2);
        do_read(1, 4, 2, d); check("R11 full width R8", d, 32'h00007E41);
        // R10: narrow access of a wide bank
        do_read(1, 0, 0, d); check("R10 one byte", d, 32'hB2);
        do_read(1, 0, 1, d); check("R10 two bytes", d, 32'hC3B2);

        // Sweep every legal width setting (R11), size, mode and many addresses.
        for (int dl = 0; dl <= 2; dl++) begin
            for (int bl = dl; bl <= 2; bl++) begin
                for (int ml = dl; ml <= 2; ml++) begin
                    set_cfg(bl, dl, ml);
                    for (int sz = 0; sz <= 2; sz++) begin
                        for (int m = 0; m < 2; m++) begin
                            for (int a = 0; a < 16'h600; a += 3) begin
                                exp = model(m[0], a, bl, dl, ml, sz, kn);
                                do_read(m[0], a, sz, d);
                                if (kn) check("R2 sweep", d, exp);
                            end
                        end
                    end
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule